// File: doc/BRIEF.md
# Four-Channel Tick Timer Bank

This block is a small bank of hardware timers that sits behind a plain register bus. The bus has a byte address, 32-bit write data, one-cycle write and read strobes and a read-data return. Three channels count down and interrupt when they pass zero. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each of these channels picks one of two slow tick-enable inputs through a bit in its control word. A fourth counter is 40 bits wide and counts up on its own faster tick. It never interrupts and is meant for fine-grained timestamps. No clocks are generated here. Every tick arrives as a single-cycle enable pulse in the `clk` domain.

Software programs a channel by writing its start value, which also loads the counter at once. It then writes the control word with the run, reload and tick-source bits. When a channel passes zero its interrupt level rises and stays high until software writes its acknowledge register. In reload mode a channel fires every start value plus one ticks. With reload off it wraps to all ones and keeps counting. The interrupt still rises in that case.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every start value, count, control word, interrupt and the 40-bit counter are zero, and every readable address returns 0.
- R2: A write to a channel's start register (offset +0x0) stores the value and copies it into the count in the same cycle. The count register (+0x4) is read-only, so writes to it change nothing.
- R3: A channel counts down by one on each pulse of its selected tick only while control bit 7 (run) is set. Control bit 3 set selects `tick_main` and clear selects `tick_alt`. The other tick, or any tick while run is clear, leaves the count unchanged.
- R4: With control bit 6 (reload) set, a tick at count zero loads the start value back into the count. Interrupts are therefore start value plus one ticks apart.
- R5: With reload clear, a tick at count zero wraps the count to all ones for the channel width (0xFFFF or 0xFFFFFFFF).
- R6: The tick at count zero raises that channel's `irq` bit (bit n for channel n). The bit stays high until it is acknowledged.
- R7: A write of any value to a channel's acknowledge register (+0xC) lowers its `irq` bit. If a zero-crossing happens in the same cycle, the bit stays high.
- R8: Channel bases are 0x00, 0x20 and 0x80. Counts and start values read back zero-extended. Control reads (+0x8) return only bits 7, 6 and 3, and the acknowledge register reads 0.
- R9: The 40-bit counter runs while bit 8 of the word at 0x64 is set and adds one per `tick_fast` pulse. It is held at zero while that bit is clear. 0x60 returns count bits 31:0, and 0x64 returns count bits 39:32 in bits 7:0 with the run flag in bit 8.
- R10: When a start-register write and a selected tick land in the same cycle, the written value goes into the count and no decrement or zero-crossing happens.
- R11: Addresses outside the map, and addresses not aligned to a word, read 0 and ignore writes. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| tick_main | input | 1 | Slow tick enable chosen when control bit 3 is set |
| tick_alt | input | 1 | Slow tick enable chosen when control bit 3 is clear |
| tick_fast | input | 1 | Fast tick enable for the 40-bit counter |
| irq | output | 3 | Interrupt levels, one per down-counting channel |

## Verification
The assertions in the RTL check several rules on every clock cycle. A zero-crossing must leave the interrupt raised and the count at either the start value or all ones, depending on the reload bit. An acknowledge without a coinciding zero-crossing must drop the interrupt. A stopped channel must keep its count. A start write must land in the count. The 40-bit counter must step by exactly one per fast tick and sit at zero while stopped. Some behaviour can only be shown by the bench scenarios driving the bus. These are the period of start value plus one, the tick-source selection, the masking of control readback, the priority of a start write over a tick, and the decoding of unmapped and misaligned addresses. The bench checks them against its behavioural model, including a long run of random bus and tick traffic.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  // Control word bit positions (software-visible)
  localparam int CTRL_RUN_BIT    = 7;
  localparam int CTRL_RELOAD_BIT = 6;
  localparam int CTRL_SRC_BIT    = 3;

  // Fast counter register offsets and run bit
  localparam int FAST_LO_OFS  = 'h60;
  localparam int FAST_HI_OFS  = 'h64;
  localparam int FAST_RUN_BIT = 8;

  // Register slot within a channel window, from address bits 3:2
  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_COUNT = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_ACK   = 2'd3
  } chan_slot_e;

  typedef struct packed {
    logic run;
    logic reload;
    logic src_main;
  } chan_ctrl_t;

  function automatic logic [31:0] ctrl_to_word(chan_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CTRL_RUN_BIT]    = c.run;
    w[CTRL_RELOAD_BIT] = c.reload;
    w[CTRL_SRC_BIT]    = c.src_main;
    return w;
  endfunction

  function automatic chan_ctrl_t word_to_ctrl(logic [31:0] w);
    chan_ctrl_t c;
    c.run      = w[CTRL_RUN_BIT];
    c.reload   = w[CTRL_RELOAD_BIT];
    c.src_main = w[CTRL_SRC_BIT];
    return c;
  endfunction

endpackage

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
  import timer_bank_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BASE   = 0,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              tick_main,
  input  logic              tick_alt,
  output logic [31:0]       rd_data,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE);
  localparam logic [CNT_W-1:0]  ALL_ONES = '1;

  // Next count after one tick
  function automatic logic [CNT_W-1:0] after_tick(logic [CNT_W-1:0] cur,
                                                  logic [CNT_W-1:0] start,
                                                  logic             reload);
    if (cur == '0) return reload ? start : ALL_ONES;
    return cur - 1'b1;
  endfunction

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  chan_ctrl_t       ctrl_q;
  logic             irq_q;

  // Decode: window match plus word alignment
  logic       hit;
  chan_slot_e slot;
  assign hit  = (addr[ADDR_W-1:4] == BASE_A[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
  assign slot = chan_slot_e'(addr[3:2]);

  // Named internal events
  logic start_wr, ctrl_wr, ack_wr, sel_tick, step, underflow;
  assign start_wr  = wr_en && hit && (slot == SLOT_START);
  assign ctrl_wr   = wr_en && hit && (slot == SLOT_CTRL);
  assign ack_wr    = wr_en && hit && (slot == SLOT_ACK);
  assign sel_tick  = ctrl_q.src_main ? tick_main : tick_alt;
  assign step      = ctrl_q.run && sel_tick && !start_wr;
  assign underflow = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (start_wr) begin
        start_q <= wdata[CNT_W-1:0];
        cnt_q   <= wdata[CNT_W-1:0];
      end else if (step) begin
        cnt_q <= after_tick(cnt_q, start_q, ctrl_q.reload);
      end
      if (ctrl_wr) ctrl_q <= word_to_ctrl(wdata);
      if (underflow)   irq_q <= 1'b1;
      else if (ack_wr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit) begin
      case (slot)
        SLOT_START: rd_data = 32'(start_q);
        SLOT_COUNT: rd_data = 32'(cnt_q);
        SLOT_CTRL:  rd_data = ctrl_to_word(ctrl_q);
        default:    rd_data = '0;
      endcase
    end
  end

  assign irq = irq_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> cnt_q == $past(wdata[CNT_W-1:0])); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !start_wr) |=> $stable(cnt_q)); // R3
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl_q.reload) |=> cnt_q == $past(start_q)); // R4
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctrl_q.reload) |=> &cnt_q); // R5
  AST_UFL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq_q); // R6
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !underflow) |=> !irq_q); // R7

endmodule

// File: rtl/tmr_fast_counter.sv
module tmr_fast_counter
  import timer_bank_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              tick_fast,
  output logic [31:0]       rd_data
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(FAST_LO_OFS);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(FAST_HI_OFS);
  localparam int HI_BITS = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic hi_wr;
  assign hi_wr = wr_en && (addr == HI_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (!run_q)         cnt_q <= '0;
      else if (tick_fast) cnt_q <= cnt_q + 1'b1;
      if (hi_wr) run_q <= wdata[FAST_RUN_BIT];
    end
  end

  logic [31:0] hi_word;
  always_comb begin
    hi_word = '0;
    hi_word[HI_BITS-1:0]  = cnt_q[CNT_W-1:32];
    hi_word[FAST_RUN_BIT] = run_q;
  end

  always_comb begin
    if (addr == LO_A)      rd_data = cnt_q[31:0];
    else if (addr == HI_A) rd_data = hi_word;
    else                   rd_data = '0;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  AST_FAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> cnt_q == '0); // R9
  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_fast) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R9
  AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_fast) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import timer_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FAST_W   = 40,
  parameter int NUM_CH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              tick_main,
  input  logic              tick_alt,
  input  logic              tick_fast,
  output logic [NUM_CH-1:0] irq
);

  logic [31:0] ch_rd [NUM_CH];
  logic [31:0] fast_rd;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    localparam int CW = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
    localparam int CB = (g == 0) ? 'h00 : (g == 1) ? 'h20 : 'h80;
    tmr_reload_chan #(
      .CNT_W (CW),
      .BASE  (CB),
      .ADDR_W(ADDR_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .wr_en    (bus_wr),
      .tick_main(tick_main),
      .tick_alt (tick_alt),
      .rd_data  (ch_rd[g]),
      .irq      (irq[g])
    );
  end

  tmr_fast_counter #(
    .CNT_W (FAST_W),
    .ADDR_W(ADDR_W)
  ) u_fast (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr_en    (bus_wr),
    .tick_fast(tick_fast),
    .rd_data  (fast_rd)
  );

  // Windows are disjoint, so an OR merges the read sources
  logic [31:0] rd_merge;
  always_comb begin
    rd_merge = fast_rd;
    for (int i = 0; i < NUM_CH; i++) rd_merge = rd_merge | ch_rd[i];
  end

  assign bus_rdata = bus_rd ? rd_merge : '0;

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R11
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|ch_rd[0], |ch_rd[1], |ch_rd[2], |fast_rd}) <= 1); // R8

endmodule

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic        tick_main = 1'b0, tick_alt = 1'b0, tick_fast = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_bank u_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr_en), .bus_rd(rd_en), .bus_rdata(rdata),
    .tick_main(tick_main), .tick_alt(tick_alt), .tick_fast(tick_fast),
    .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint m_start[3], m_cnt[3];
  bit     m_run[3], m_rel[3], m_main[3], m_irq[3];
  longint m_fc;
  bit     m_frun;

  function automatic int base_of(int i);
    return (i == 0) ? 0 : (i == 1) ? 32 : 128;
  endfunction
  function automatic longint mask_of(int i);
    return (i == 2) ? 64'hFFFF_FFFF : 64'hFFFF;
  endfunction

  function automatic longint model_read(int a);
    for (int i = 0; i < 3; i++) begin
      if (a == base_of(i))      return m_start[i];
      if (a == base_of(i) + 4)  return m_cnt[i];
      if (a == base_of(i) + 8)  return (longint'(m_run[i]) << 7) | (longint'(m_rel[i]) << 6) | (longint'(m_main[i]) << 3);
      if (a == base_of(i) + 12) return 0;
    end
    if (a == 96)  return m_fc & 64'hFFFF_FFFF;
    if (a == 100) return (longint'(m_frun) << 8) | ((m_fc >> 32) & 64'hFF);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_start[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_rel[i] = 0; m_main[i] = 0; m_irq[i] = 0;
      end
      m_fc = 0; m_frun = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit tk;
        bit uf;
        int b;
        b  = base_of(i);
        tk = m_main[i] ? tick_main : tick_alt;
        uf = 0;
        if (wr_en && addr == b) begin
          m_start[i] = longint'(wdata) & mask_of(i);
          m_cnt[i]   = m_start[i];
        end else if (m_run[i] && tk) begin
          if (m_cnt[i] == 0) begin
            uf = 1;
            m_cnt[i] = m_rel[i] ? m_start[i] : mask_of(i);
          end else m_cnt[i] = m_cnt[i] - 1;
        end
        if (wr_en && addr == b + 8) begin
          m_run[i] = wdata[7]; m_rel[i] = wdata[6]; m_main[i] = wdata[3];
        end
        if (uf) m_irq[i] = 1;
        else if (wr_en && addr == b + 12) m_irq[i] = 0;
      end
      if (!m_frun) m_fc = 0;
      else if (tick_fast) m_fc = (m_fc + 1) & 64'hFF_FFFF_FFFF;
      if (wr_en && addr == 100) m_frun = wdata[8];
    end
  end

  // Every-cycle comparison of interrupt levels (R6, R7)
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < 3; i++) chk("R6/R7 irq vs model", irq[i], m_irq[i]);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(int a, longint d);
    @(negedge clk);
    addr = 8'(a); wdata = 32'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdx(int a, longint exp, string req);
    @(negedge clk);
    addr = 8'(a); rd_en = 1'b1;
    #1;
    chk(req, rdata, exp);
    chk({req, " model"}, rdata, model_read(a));
    rd_en = 1'b0;
  endtask

  task automatic ticks(bit tm, bit ta, bit tf, int n);
    @(negedge clk);
    tick_main = tm; tick_alt = ta; tick_fast = tf;
    repeat (n) @(negedge clk);
    tick_main = 0; tick_alt = 0; tick_fast = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1: reset state
    chk("R1 irq after reset", irq, 0);
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < 4; k++) rdx(base_of(i) + 4*k, 0, "R1 reset read");
    rdx(96, 0, "R1 fast lo reset");
    rdx(100, 0, "R1 fast hi reset");

    // R2: start write loads count, count register is read-only
    wr(0, 3);
    rdx(4, 3, "R2 count copied");
    wr(4, 'h55);
    rdx(4, 3, "R2 count read-only");
    rdx(0, 3, "R2 start kept");

    // R8: control readback masking, channel 1
    wr('h28, 'h37);
    rdx('h28, 0, "R8 ctrl masked");

    // R3/R4/R6: channel 0 run, reload, main tick
    wr(8, 'hC8);
    rdx(8, 'hC8, "R8 ctrl readback");
    ticks(0, 1, 0, 5);
    rdx(4, 3, "R3 other tick ignored");
    ticks(1, 0, 0, 3);
    rdx(4, 0, "R3 three decrements");
    chk("R6 no irq before zero crossing", irq[0], 0);
    ticks(1, 0, 0, 1);
    rdx(4, 3, "R4 reload after start+1 ticks");
    chk("R6 irq raised", irq[0], 1);
    ticks(1, 0, 0, 2);
    chk("R6 irq level held", irq[0], 1);

    // R7: acknowledge, then acknowledge racing a zero crossing
    wr(12, 'h0);
    chk("R7 ack clears", irq[0], 0);
    rdx(4, 1, "R3 count before race");
    ticks(1, 0, 0, 1);
    @(negedge clk);
    tick_main = 1; addr = 12; wdata = 32'hDEAD; wr_en = 1;
    @(negedge clk);
    tick_main = 0; wr_en = 0;
    chk("R7 crossing beats ack", irq[0], 1);
    wr(12, 'h1234);
    chk("R7 ack after race", irq[0], 0);

    // R5: channel 2 wrap, alt tick
    wr('h80, 2);
    wr('h88, 'h80);
    ticks(0, 1, 0, 3);
    rdx('h84, 64'hFFFF_FFFF, "R5 32-bit wrap");
    chk("R6 irq on wrap", irq[2], 1);
    wr('h8C, 0);

    // R10: start write with a selected tick
    @(negedge clk);
    tick_alt = 1; addr = 'h80; wdata = 'h10; wr_en = 1;
    @(negedge clk);
    tick_alt = 0; wr_en = 0;
    rdx('h84, 'h10, "R10 write beats tick");
    chk("R10 no irq", irq[2], 0);

    // R3: stopped channel holds
    wr('h88, 'h00);
    ticks(1, 1, 0, 4);
    rdx('h84, 'h10, "R3 stopped holds");

    // R5: 16-bit wrap on channel 1
    wr('h20, 0);
    wr('h28, 'h88);
    ticks(1, 0, 0, 1);
    rdx('h24, 'hFFFF, "R5 16-bit wrap");
    wr('h28, 0);
    wr('h2C, 0);

    // R9: fast counter
    ticks(0, 0, 1, 3);
    rdx(96, 0, "R9 stopped stays zero");
    wr(100, 'h100);
    ticks(0, 0, 1, 5);
    rdx(96, 5, "R9 counts fast ticks");
    rdx(100, 'h100, "R9 hi word and run flag");
    ticks(1, 1, 0, 4);
    rdx(96, 5, "R9 slow ticks ignored");
    wr(100, 0);
    rdx(96, 0, "R9 cleared when stopped");
    rdx(100, 0, "R9 hi cleared");

    // R11: unmapped and misaligned
    wr('h40, 'hFFFF_FFFF);
    rdx('h40, 0, "R11 unmapped");
    wr(2, 'h77);
    rdx(2, 0, "R11 misaligned read");
    rdx(0, 3, "R11 misaligned write ignored");
    @(negedge clk);
    addr = 0; #1;
    chk("R11 no read strobe", rdata, 0);

    // Random traffic against the model
    for (int c = 0; c < 600; c++) begin
      int sel;
      int a;
      @(negedge clk);
      sel = $urandom % 18;
      if (sel < 12)       a = base_of(sel / 4) + 4 * (sel % 4);
      else if (sel == 12) a = 96;
      else if (sel == 13) a = 100;
      else if (sel == 14) a = 'h40;
      else if (sel == 15) a = 'h62;
      else if (sel == 16) a = 'h83;
      else                a = 'hF0;
      addr = 8'(a);
      wr_en = ($urandom % 4) == 0;
      wdata = ((sel % 4) == 0 && sel < 12) ? ($urandom % 6) : $urandom;
      tick_main = $urandom % 2; tick_alt = $urandom % 3 == 0; tick_fast = 1'($urandom);
      rd_en = 1;
      #1;
      chk("R8 random read vs model", rdata, model_read(a));
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick_main = 0; tick_alt = 0; tick_fast = 0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule